// File: doc/BRIEF.md
# Quasi-Bidirectional Port Controller

This block is the digital control for an eight-pin general-purpose port whose pins have no direction setting. Each pin has one output latch bit. A pin whose latch holds 0 is pulled low hard. A pin whose latch holds 1 is held high only by an always-present weak pull-up in the pad. A device outside can then pull that pin low, so the same pin can serve as an input. When a write changes a latch bit from 0 to 1, the block turns on a strong pull-up for that pin for a short time, which gives a fast rising edge into a heavily loaded line. The strong pull-up turns off at the next falling edge of the serial-bus clock.

A serial-bus slave in front of the block delivers one-cycle write strobes that carry a data byte. It also passes through the raw bus clock, and the block detects that clock's falling edges in the system clock domain. Reads return the live pad levels after two synchronising flip-flops, not the latch contents. To read a pin as an input, software must first write 1 to its latch bit.

Top module: `qb_port_ctrl`

## Requirements
- R1: While reset is held, every latch bit takes the value 1. One clock edge later `pdn_en` is all 0 and `boost_en` is all 0.
- R2: A write (`wr_stb` high for one cycle) loads `wr_data` into the latch. From the next cycle on, `pdn_en[i]` is 1 exactly when latch bit i is 0.
- R3: When a write changes latch bit i from 0 to 1, `boost_en[i]` is 1 in the cycle after the write.
- R4: A write does not set `boost_en[i]` when bit i was already 1 and is written 1 again, or when bit i is written 0.
- R5: `boost_en` bits that are set stay set while `bus_scl` stays high or rises. They clear on the third rising edge of `clk` after `bus_scl` falls, which allows two edges of synchronisation and one edge of detection.
- R6: No pin ever has `boost_en[i]` and `pdn_en[i]` high together. Writing 0 to a boosted bit clears its boost.
- R7: `rd_data` follows the pad levels `pin_in` through two flip-flops, so a change shows after two rising edges of `clk`. A pin whose latch is 1 reads 0 when it is pulled low from outside.
- R8: Boost bits are independent. A bus-clock fall clears only the bits that are set at that time. A bit set by a later write stays set until the next fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_stb | input | 1 | One-cycle port write strobe from the bus slave |
| wr_data | input | 8 | Byte to load into the output latch |
| bus_scl | input | 1 | Raw serial-bus clock, asynchronous to `clk` |
| pin_in | input | 8 | Pad levels as seen at the pins |
| pdn_en | output | 8 | Per-pin pull-down enable |
| boost_en | output | 8 | Per-pin strong pull-up enable |
| rd_data | output | 8 | Synchronised pad levels for port reads |

## Verification
The hardest case to reach is the timing of the strong pull-up. It has to stay on through many idle cycles and through a rising bus-clock edge, and then drop on an exact cycle after a bus-clock fall. In that window the pull-down of another bit must not switch on and overlap it. The bench holds `bus_scl` high across a write, samples `boost_en` one cycle before and on the expected clear cycle, and then repeats with two bits boosted at different times. A second hard case is reading a pin as an input while its latch is 1. For this the bench models each pad as a wired-AND of the pull-down, an outside low driver and an implied pull-up.

// File: rtl/qb_pkg.sv
// Package: shared definitions for the quasi-bidirectional port controller.
// Assumes: nothing beyond standard SystemVerilog.
package qb_pkg;
    // Drive request produced by one pin cell.
    typedef struct packed {
        logic pull_dn;
        logic boost;
    } pin_drive_t;

    // Level the bus clock is assumed to idle at.
    localparam logic SCL_IDLE = 1'b1;
endpackage

// File: rtl/qb_scl_fall.sv
// Module: qb_scl_fall
// Brings the asynchronous bus clock into the clk domain through a chain of
// STAGES flip-flops. It flags one clk cycle for each falling edge seen.
// Assumes: bus_scl high and low phases each last longer than a clk period.
module qb_scl_fall
    import qb_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_scl,
    output logic scl_fall
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] sync_q;
    logic          prev_q;

    // Shift the bus clock through the synchroniser and keep the previous value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= {STAGES{SCL_IDLE}};
            prev_q <= SCL_IDLE;
        end else begin
            sync_q <= {sync_q[LAST-1:0], bus_scl};
            prev_q <= sync_q[LAST];
        end
    end

    // Falling edge: was high, is now low.
    always_comb scl_fall = prev_q & ~sync_q[LAST];
endmodule

// File: rtl/qb_pin_cell.sv
// Module: qb_pin_cell
// One pin: an output latch bit, plus a strong pull-up request that is armed
// by a 0->1 write and dropped by the next bus-clock fall or by a write of 0.
// Assumes: wr_stb lasts one clk cycle per write.
module qb_pin_cell
    import qb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_stb,
    input  logic       wr_bit,
    input  logic       scl_fall,
    output pin_drive_t drive
);
    logic latch_q;
    logic boost_q;
    logic rise_req;

    // A write that turns a 0 into a 1 asks for the strong pull-up.
    always_comb rise_req = wr_stb & wr_bit & ~latch_q;

    // Output latch: all ones after reset, loaded on each write.
    always_ff @(posedge clk) begin
        if (!rst_n)      latch_q <= 1'b1;
        else if (wr_stb) latch_q <= wr_bit;
    end

    // Strong pull-up: a new rise wins over a fall in the same cycle; a write of 0 clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)                 boost_q <= 1'b0;
        else if (rise_req)          boost_q <= 1'b1;
        else if (wr_stb && !wr_bit) boost_q <= 1'b0;
        else if (scl_fall)          boost_q <= 1'b0;
    end

    // Drive request for the pad.
    always_comb begin
        drive.pull_dn = ~latch_q;
        drive.boost   = boost_q;
    end
endmodule

// File: rtl/qb_in_sync.sv
// Module: qb_in_sync
// A synchroniser of STAGES flip-flops for a WIDTH-bit vector of pad levels.
// Assumes: each bit is handled on its own; no cross-bit coherence is promised.
module qb_in_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] chain_q [STAGES];

    // Capture stage: reset to high, the level of an idle pad.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= '1;
        else        chain_q[0] <= d_async;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Each further stage re-registers the one before it.
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q[s] <= '1;
            else        chain_q[s] <= chain_q[s-1];
        end
    end

    always_comb q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/qb_port_ctrl.sv
// Module: qb_port_ctrl (top)
// Control for a quasi-bidirectional port: per-pin latch, pull-down enable,
// one-shot strong pull-up timed by the bus clock's falling edge, and
// synchronised read-back of the pad levels.
// Assumes: the pads supply a weak pull-up at all times; bus_scl is asynchronous.
module qb_port_ctrl
    import qb_pkg::*;
#(
    parameter int WIDTH      = 8,
    parameter int SYNC_DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             bus_scl,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pdn_en,
    output logic [WIDTH-1:0] boost_en,
    output logic [WIDTH-1:0] rd_data
);
    logic       scl_fall;
    pin_drive_t drv [WIDTH];

    // Bus-clock falling-edge detector.
    qb_scl_fall #(.STAGES(SYNC_DEPTH)) u_fall (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_scl  (bus_scl),
        .scl_fall (scl_fall)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        // One latch and boost cell per pin.
        qb_pin_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_stb   (wr_stb),
            .wr_bit   (wr_data[i]),
            .scl_fall (scl_fall),
            .drive    (drv[i])
        );
        // Spread the drive request out to the pad outputs.
        always_comb begin
            pdn_en[i]   = drv[i].pull_dn;
            boost_en[i] = drv[i].boost;
        end
    end

    // Read path: synchronised pad levels.
    qb_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_DEPTH)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pin_in),
        .q_sync  (rd_data)
    );
endmodule

// File: rtl/qb_port_chk.sv
// Module: qb_port_chk
// Checker bound to qb_port_ctrl. It watches the port outputs together with the
// internal falling-edge flag.
// Assumes: synchronous active-low reset.
module qb_port_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_stb,
    input logic [WIDTH-1:0] wr_data,
    input logic             scl_fall,
    input logic [WIDTH-1:0] pdn_en,
    input logic [WIDTH-1:0] boost_en
);
    logic [WIDTH-1:0] rise_mask;

    // Bits that the current write turns from 0 to 1.
    always_comb rise_mask = wr_stb ? (wr_data & pdn_en) : '0;

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (pdn_en == '0 && boost_en == '0));  // R1
    AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> pdn_en == ~$past(wr_data));  // R2
    AST_BOOST_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> (boost_en & $past(rise_mask)) == $past(rise_mask));  // R3
    AST_BOOST_ONLY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (boost_en & ~$past(boost_en) & ~$past(rise_mask)) == '0);  // R4
    AST_BOOST_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        scl_fall |=> (boost_en & ~$past(rise_mask)) == '0);  // R5
    AST_NO_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (boost_en & pdn_en) == '0);  // R6
endmodule

bind qb_port_ctrl qb_port_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_stb   (wr_stb),
    .wr_data  (wr_data),
    .scl_fall (scl_fall),
    .pdn_en   (pdn_en),
    .boost_en (boost_en)
);

// File: tb/sim_qb_port_ctrl.sv
// Bench for qb_port_ctrl: directed scenarios, one task each. The pads are
// modelled as a wired-AND of the pull-down, an outside low driver and a pull-up.
module sim_qb_port_ctrl;
    localparam int  W        = 8;
    localparam time CLK_HALF = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_stb = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         bus_scl = 1'b1;
    logic [W-1:0] ext_low = '0;
    logic [W-1:0] pad;
    logic [W-1:0] pdn_en, boost_en, rd_data;
    logic [W-1:0] lat_model = '1;
    int           n_run = 0;
    int           n_fail = 0;

    always #(CLK_HALF) clk = ~clk;

    // Resolved pad level: low if either side pulls low, else the weak pull-up wins.
    assign pad = ~(pdn_en | ext_low);

    qb_port_ctrl #(.WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
        .bus_scl(bus_scl), .pin_in(pad), .pdn_en(pdn_en),
        .boost_en(boost_en), .rd_data(rd_data)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic port_write(input logic [W-1:0] d);
        @(negedge clk);
        wr_stb = 1'b1; wr_data = d;
        @(negedge clk);
        wr_stb = 1'b0;
        lat_model = d;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic t_reset;
        idle(3);
        chk("R1 pdn_en", pdn_en, '0);
        chk("R1 boost_en", boost_en, '0);
        rst_n = 1'b1;
        idle(3);
        chk("R1 rd_data idle high", rd_data, '1);
    endtask

    task automatic t_latch;
        port_write(8'hA5);
        chk("R2 pdn after A5", pdn_en, ~8'hA5);
        port_write(8'h00);
        chk("R2 pdn after 00", pdn_en, 8'hFF);
        chk("R6 zero clears boost", boost_en, '0);
    endtask

    task automatic t_boost_rise;
        port_write(8'h3C);
        chk("R3 boost on rise", boost_en, 8'h3C);
        idle(20);
        chk("R5 boost held scl high", boost_en, 8'h3C);
        chk("R6 no overlap", boost_en & pdn_en, '0);
    endtask

    task automatic t_boost_drop;
        @(negedge clk); bus_scl = 1'b0;
        idle(2);
        chk("R5 boost before clear edge", boost_en, 8'h3C);
        idle(1);
        chk("R5 boost cleared after fall", boost_en, '0);
        idle(2); bus_scl = 1'b1;
        idle(5);
    endtask

    task automatic t_no_boost;
        port_write(8'h3C);
        chk("R4 rewrite 1 no boost", boost_en, '0);
        port_write(8'h0C);
        chk("R4 write 0 no boost", boost_en, '0);
        chk("R2 pdn after 0C", pdn_en, ~8'h0C);
    endtask

    task automatic t_zero_kills;
        port_write(8'h00);
        port_write(8'hF0);
        chk("R3 boost F0", boost_en, 8'hF0);
        port_write(8'h30);
        chk("R6 zero write drops boost", boost_en, 8'h30);
        chk("R6 no overlap after 30", boost_en & pdn_en, '0);
    endtask

    task automatic t_independent;
        // bits 4,5 still boosted from the previous task
        @(negedge clk); bus_scl = 1'b0;
        idle(4);
        chk("R8 fall clears all", boost_en, '0);
        port_write(8'h31);
        chk("R8 new bit set after fall", boost_en, 8'h01);
        bus_scl = 1'b1;
        idle(6);
        chk("R8 rise keeps new bit", boost_en, 8'h01);
        bus_scl = 1'b0;
        idle(4);
        chk("R8 next fall clears", boost_en, '0);
        bus_scl = 1'b1;
        idle(4);
    endtask

    task automatic t_read;
        port_write(8'hFF);
        idle(3);
        chk("R7 all high", rd_data, 8'hFF);
        @(negedge clk); ext_low = 8'h81;
        idle(1);
        chk("R7 one edge not yet", rd_data, 8'hFF);
        idle(1);
        chk("R7 input pulled low", rd_data, 8'h7E);
        @(negedge clk); ext_low = '0;
        port_write(8'h0F);
        idle(3);
        chk("R7 reads pad not latch", rd_data, 8'h0F);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        t_reset();
        t_latch();
        t_boost_rise();
        t_boost_drop();
        t_no_boost();
        t_zero_kills();
        t_independent();
        t_read();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule